// File: doc/BRIEF.md
# Branch-Capable Instruction Fetch Unit

This block is the front end of a single-cycle processor core. It holds the program counter and reads the current instruction word from a small instruction store using a combinational read. On every rising clock edge it moves the program counter forward, either to the next sequential word or to a branch target.

The branch target is formed from the low 16 bits of the instruction now being fetched. The choice between target and sequential address comes from two plain inputs: a branch-select strobe from the decoder and the equality flag from the ALU. Decode, register access and ALU work sit outside the block.

A loader port fills the instruction store before a run. It accepts writes only while reset is held.

Top module: `ifu_fetch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0x00000000.
- R2: `instr` always shows the 32-bit store word whose index is `pc[11:2]`, in the same cycle as `pc`. The store holds 1024 words, so addresses above 4 KiB alias onto it. `pc[1:0]` is always 0.
- R3: With `br_sel` = 0 and `alu_zero` = 0, each rising edge out of reset loads `pc + 4` into the program counter.
- R4: With `br_sel` = 1 and `alu_zero` = 1, the edge loads `pc + 4 + (sext(instr[15:0]) << 2)`. The immediate is bits 15..0 of the current instruction.
- R5: A negative immediate (bit 15 = 1) moves the program counter backwards, following the formula in R4.
- R6: When exactly one of `br_sel` and `alu_zero` is 1, the edge loads `pc + 4`.
- R7: All address sums wrap modulo 2^32. For example, a branch at PC 0 with immediate 0xFFFE goes to 0xFFFFFFFC, which fetches store word 1023. The step after that returns to 0.
- R8: When `load_en` = 1 while `rst_n` = 0, the rising edge writes `load_data` into store word `load_addr`.
- R9: When `load_en` = 1 while `rst_n` = 1, the store contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_sel | input | 1 | Branch requested by the decoder |
| alu_zero | input | 1 | ALU equality flag |
| load_en | input | 1 | Loader write strobe, effective only in reset |
| load_addr | input | 10 | Loader word index |
| load_data | input | 32 | Loader write data |
| instr | output | 32 | Instruction word at the current program counter |
| pc | output | 32 | Current program counter |

## Verification
Two kinds of result have different timing:
- `instr` is combinational in `pc`, so it is due in the cycle that `pc` holds a value.
- A new `pc` is due exactly one rising edge after the cycle in which `br_sel`, `alu_zero` and the current immediate were presented.

The bench drives its inputs on the falling edge. It compares `instr` against its own model store just after that. It then waits for one rising edge and compares `pc` on the next falling edge against a model program counter that advanced once.

Loader writes follow the same rule, showing up in `instr` from the cycle after the write edge. This is also how the ignored write in R9 is observed through the fetch path.

// File: rtl/ifu_pkg.sv
// Package: shared sizes and helpers for the fetch unit.
// Assumes byte addressing with 4-byte instruction words.
package ifu_pkg;
    localparam int WORD_BYTES_LOG2 = 2;

    // Sign-extend an immediate and scale it to a byte displacement.
    function automatic logic [31:0] branch_disp(input logic [15:0] imm);
        return {{14{imm[15]}}, imm, 2'b00};
    endfunction
endpackage

// File: rtl/ifu_imem.sv
// Instruction store: one write port on the clock, combinational read.
// Assumes the caller qualifies wr_en; the write index is already in range.
module ifu_imem #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] store [DEPTH];

    // Capture a loader word on the rising edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    // Read path has no register: data follows the index at once.
    assign rd_data = store[rd_idx];
endmodule

// File: rtl/ifu_next_pc.sv
// Next-address logic: two adders run side by side, a mux picks one.
// Assumes the immediate is a word offset relative to pc + 4.
module ifu_next_pc #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IMM_W-1:0]  imm,
    input  logic              take,
    output logic [ADDR_W-1:0] next_pc
);
    localparam int EXT_W = ADDR_W - IMM_W - 2;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] tgt_pc;

    // Sequential address, wrapping on overflow.
    assign seq_pc = pc + ADDR_W'(4);

    // Sign-extended, word-scaled displacement.
    assign disp = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};

    // Branch target, formed alongside the sequential sum.
    assign tgt_pc = seq_pc + disp;

    // Select the target only on a taken branch.
    always_comb begin
        next_pc = take ? tgt_pc : seq_pc;
    end
endmodule

// File: rtl/ifu_pc_reg.sv
// Program counter register with synchronous active-low clear.
// Assumes next_pc is word aligned.
module ifu_pc_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] pc
);
    // Clear in reset, otherwise advance every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            pc <= next_pc;
        end
    end
endmodule

// File: rtl/ifu_fetch.sv
// Top of the fetch unit: PC register, instruction store, next-address logic.
// Assumes loader writes happen only during reset; other writes are dropped.
module ifu_fetch #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 10,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_sel,
    input  logic              alu_zero,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_addr,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] instr,
    output logic [ADDR_W-1:0] pc
);
    localparam int IDX_LO = ifu_pkg::WORD_BYTES_LOG2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [ADDR_W-1:0] next_pc;
    logic              take;
    logic              store_we;

    // A branch is taken only when both controls agree.
    assign take     = br_sel & alu_zero;
    // Loader port is honoured only while reset is held.
    assign store_we = load_en & ~rst_n;

    ifu_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .next_pc (next_pc),
        .pc      (pc)
    );

    ifu_imem #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .wr_en   (store_we),
        .wr_idx  (load_addr),
        .wr_data (load_data),
        .rd_idx  (pc[IDX_HI:IDX_LO]),
        .rd_data (instr)
    );

    ifu_next_pc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_npc (
        .pc      (pc),
        .imm     (instr[IMM_W-1:0]),
        .take    (take),
        .next_pc (next_pc)
    );
endmodule

// File: rtl/ifu_fetch_chk.sv
// Checker for the fetch unit: relates controls, immediate and PC over time.
// Assumes the default 32-bit address and 16-bit immediate.
module ifu_fetch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        br_sel,
    input logic        alu_zero,
    input logic [31:0] instr,
    input logic [31:0] pc
);
    logic rst_prev = 1'b0;

    // Remember whether the previous edge saw reset.
    always_ff @(posedge clk) begin
        rst_prev <= !rst_n;
    end

    // R1: an edge in reset leaves the PC at zero.
    always @(posedge clk) begin
        if (rst_prev) begin
            assert_reset_pc_R1: assert (pc == 32'h0)
                else $error("R1 pc not cleared");
        end
    end

    // R2: fetch addresses stay word aligned.
    assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    // R3 and R6: no taken branch means a plain step of four.
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_sel && alu_zero) |=> pc == $past(pc) + 32'd4);

    // R4 and R5: a taken branch lands on the scaled target.
    assert_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && alu_zero) |=>
        pc == $past(pc) + 32'd4 + ifu_pkg::branch_disp($past(instr[15:0])));
endmodule

bind ifu_fetch ifu_fetch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_sel   (br_sel),
    .alu_zero (alu_zero),
    .instr    (instr),
    .pc       (pc)
);

// File: tb/sim_ifu_fetch.sv
`timescale 1ns/1ps
module sim_ifu_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_sel = 1'b0;
    logic        alu_zero = 1'b0;
    logic        load_en = 1'b0;
    logic [9:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] instr;
    logic [31:0] pc;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] ref_mem [1024];
    logic [31:0] mpc = '0;

    always #2 clk = ~clk;

    ifu_fetch u0 (
        .clk(clk), .rst_n(rst_n), .br_sel(br_sel), .alu_zero(alu_zero),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .instr(instr), .pc(pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle, called on a falling edge: drive, check fetch, clock, check PC.
    task automatic tick(input logic rst, input logic br, input logic z,
                        input logic le, input logic [9:0] la, input logic [31:0] ld,
                        input string tag_over = "");
        logic [31:0] w;
        logic [31:0] nxt;
        string tag;
        rst_n = rst; br_sel = br; alu_zero = z;
        load_en = le; load_addr = la; load_data = ld;
        #0.5;
        w = ref_mem[mpc[11:2]];
        if (rst) chk("R2 instr", instr, w);
        if (!rst) begin
            nxt = 32'h0; tag = "R1";
            if (le) ref_mem[la] = ld;
        end else if (br && z) begin
            nxt = mpc + 32'd4 + 32'(4 * int'($signed(w[15:0])));
            tag = w[15] ? "R5" : "R4";
        end else begin
            nxt = mpc + 32'd4;
            tag = (br || z) ? "R6" : "R3";
        end
        if (tag_over != "") tag = tag_over;
        @(posedge clk);
        @(negedge clk);
        mpc = nxt;
        chk({tag, " pc"}, pc, mpc);
    endtask

    initial begin
        @(negedge clk);
        // Fill the store in reset (R8), with a varied immediate per word.
        for (int k = 0; k < 1024; k++) begin
            logic [31:0] d;
            d = {16'hC000 ^ 16'(k), 16'(k * 13 - 300)};
            if (k == 0) d = 32'h11110003;
            if (k == 4) d = 32'h4444FFFD;
            tick(1'b0, 1'b0, 1'b0, 1'b1, 10'(k), d, "R8");
        end
        chk("R1 pc in reset", pc, 32'h0);
        // Out of reset: sequential steps and one-sided controls.
        tick(1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
        tick(1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
        tick(1'b1, 1'b0, 1'b1, 1'b0, '0, '0);
        tick(1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
        chk("R3 pc after four steps", pc, 32'h10);
        // Word 4 has a negative immediate: backward branch (R5).
        tick(1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
        chk("R5 backward target", pc, 32'h8);
        // Forward and mixed traffic.
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 3);
            tick(1'b1, r[0], r[1], 1'b0, '0, '0);
        end
        // R9: a loader write out of reset must not land.
        tick(1'b1, 1'b0, 1'b0, 1'b1, 10'd0, 32'hDEADBEEF);
        tick(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
        #0.5;
        chk("R9 word 0 unchanged", instr, 32'h11110003);
        // Branch from PC 0 with imm 3: target 16 (R4).
        tick(1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
        chk("R4 forward target", pc, 32'h10);
        // R8 then R7: load imm 0xFFFE at word 0, branch across zero.
        tick(1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 32'h7777FFFE);
        #0.5;
        chk("R8 loaded word visible", instr, 32'h7777FFFE);
        tick(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, "R7");
        chk("R7 wrapped target", pc, 32'hFFFFFFFC);
        #0.5;
        chk("R7 alias word 1023", instr, ref_mem[1023]);
        tick(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, "R7");
        chk("R7 wrap to zero", pc, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule